// File: doc/BRIEF.md
# Sequenced Half-Bridge Gate Glitch Trigger

This block looks for shoot-through risk in a half-bridge converter. It takes two streams of signed 12-bit samples, one from the low-side gate drive and one from the high-side gate drive, at one sample per clock. It raises a one-cycle trigger pulse when a short glitch appears on the high-side gate after the low-side gate has switched off. The detectors work directly on the acquired samples, with no separate filtered path.

The sequence has two states. While the block waits for arming, a falling edge on the low-side stream arms it. A falling edge here means a drop below a programmable level, seen with hysteresis. Once armed, a short pulse on the high-side stream is accepted as the qualifying event. That pulse must cross a level in a selected direction and come back past that level less a hysteresis margin within a bounded number of samples. If no qualifying pulse arrives within a programmable number of samples after arming, the block drops back to waiting. Each accepted pulse fires the trigger, adds one to a saturating event counter and returns the sequence to waiting for a new arming edge. All levels, margins, polarity, pulse width and timeout come from static configuration inputs.

Top module: `seq_glitch_trig`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to the waiting state: `armed_o`=0, `trig_o`=0 and `trig_cnt_o`=0.
- R2: A low-side falling edge occurs on a sample below `lo_lvl` when an earlier sample, taken since the previous edge, was at or above `lo_lvl + lo_hyst`. A falling edge seen while waiting makes `armed_o` read 1 after that sample's clock edge.
- R3: A low-side sample below `lo_lvl` does not arm the block when no sample at or above `lo_lvl + lo_hyst` came after the previous edge.
- R4: With `hi_pol_pos`=1, a high-side pulse starts on a sample at or above `hi_lvl` and ends on the first later sample below `hi_lvl - hi_hyst`. With `hi_pol_pos`=0, it starts on a sample at or below `hi_lvl` and ends on the first later sample above `hi_lvl + hi_hyst`. The width counts the samples from the start sample up to the ending sample, not including the ending sample. A pulse is a glitch only when its width is at most `hi_wmax`.
- R5: High-side samples that lie between the level and the level offset by the hysteresis do not end a pulse. They add to its width.
- R6: A glitch that ends while the block is waiting for arming has no effect on `trig_o` or `trig_cnt_o`.
- R7: A glitch that ends while the block is armed drives `trig_o` high for exactly the one cycle after the ending sample, and `armed_o` reads 0 in that same cycle.
- R8: Number the samples after the arming sample 1, 2, and so on, and let N = `tmo_len`, or 1 when `tmo_len` is 0. A glitch that ends on sample k ≤ N fires the trigger. If sample N passes without a glitch, `armed_o` falls after that sample.
- R9: A new low-side falling edge while the block is armed restarts the sample numbering of R8 from that edge.
- R10: When a glitch end and a low-side falling edge fall on the same armed sample, the glitch wins: the trigger fires and the block waits for arming.
- R11: `trig_cnt_o` rises by one with each trigger pulse, changes at no other time except reset, and holds at all ones once it reaches that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_smp | input | 12 | Low-side gate sample, signed |
| hi_smp | input | 12 | High-side gate sample, signed |
| lo_lvl | input | 12 | Low-side edge level, signed |
| lo_hyst | input | 11 | Low-side hysteresis, unsigned |
| hi_lvl | input | 12 | High-side glitch level, signed |
| hi_hyst | input | 11 | High-side hysteresis, unsigned |
| hi_pol_pos | input | 1 | 1: positive-going glitch, 0: negative-going |
| hi_wmax | input | WID_W (8) | Longest pulse width, in samples, that counts as a glitch |
| tmo_len | input | TO_W (24) | Armed window length in samples |
| trig_o | output | 1 | One-cycle trigger pulse |
| armed_o | output | 1 | Sequence armed, waiting for a glitch |
| trig_cnt_o | output | CNT_W (16) | Saturating trigger count |

## Verification
The main function is driven with paired low-side and high-side patterns. Clean arming edges followed by short pulses separate correct triggering from missed events. Glitches placed before any arming edge show that unarmed pulses are dropped. Dips that never cleared the low-side hysteresis band separate real edges from noise. Pulses of width equal to and one above the limit pin down the width comparison. Further patterns place a pulse on the last sample of the window and just after it, restart the window with a second edge, end a pulse together with an edge, end a pulse inside the return hysteresis, and use negative polarity; each of these isolates one ordering rule.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  localparam int SMP_W = 12;
  localparam int HYS_W = SMP_W - 1;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [SMP_W:0]   wide_t;
  typedef logic [HYS_W-1:0]        hys_t;

  typedef enum logic {ST_WAIT_A = 1'b0, ST_WAIT_B = 1'b1} seq_st_t;

  function automatic wide_t widen(smp_t v);
    return wide_t'({v[SMP_W-1], v});
  endfunction

  function automatic wide_t hwide(hys_t h);
    return wide_t'({2'b00, h});
  endfunction

  // sample at or above level + margin
  function automatic logic above_band(smp_t s, smp_t lvl, hys_t h);
    return widen(s) >= (widen(lvl) + hwide(h));
  endfunction

  function automatic logic below_lvl(smp_t s, smp_t lvl);
    return widen(s) < widen(lvl);
  endfunction

  // pulse start in the selected direction
  function automatic logic past_lvl(smp_t s, smp_t lvl, logic pos);
    return pos ? (widen(s) >= widen(lvl)) : (widen(s) <= widen(lvl));
  endfunction

  // pulse end: back across level by more than the margin
  function automatic logic back_out(smp_t s, smp_t lvl, hys_t h, logic pos);
    return pos ? (widen(s) < (widen(lvl) - hwide(h)))
               : (widen(s) > (widen(lvl) + hwide(h)));
  endfunction
endpackage

// File: rtl/sgt_fall_edge.sv
module sgt_fall_edge
  import sgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  smp_t smp,
  input  smp_t lvl,
  input  hys_t hyst,
  output logic fall_o
);
  logic primed_q;

  assign fall_o = primed_q && below_lvl(smp, lvl);

  always_ff @(posedge clk) begin
    if (rst)                         primed_q <= 1'b0;
    else if (above_band(smp, lvl, hyst)) primed_q <= 1'b1;
    else if (fall_o)                 primed_q <= 1'b0;
  end
endmodule

// File: rtl/sgt_glitch.sv
module sgt_glitch
  import sgt_pkg::*;
#(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  smp_t             smp,
  input  smp_t             lvl,
  input  hys_t             hyst,
  input  logic             pos,
  input  logic [WID_W-1:0] wmax,
  output logic             glitch_o
);
  localparam logic [WID_W-1:0] W_TOP = '1;

  logic             in_q;
  logic [WID_W-1:0] w_q;
  logic             start_w;
  logic             end_w;

  assign start_w  = !in_q && past_lvl(smp, lvl, pos);
  assign end_w    = in_q && back_out(smp, lvl, hyst, pos);
  assign glitch_o = end_w && (w_q <= wmax);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= 1'b0;
      w_q  <= '0;
    end else if (start_w) begin
      in_q <= 1'b1;
      w_q  <= WID_W'(1);
    end else if (end_w) begin
      in_q <= 1'b0;
      w_q  <= '0;
    end else if (in_q && (w_q != W_TOP)) begin
      w_q  <= w_q + WID_W'(1);
    end
  end
endmodule

// File: rtl/sgt_seq.sv
module sgt_seq
  import sgt_pkg::*;
#(
  parameter int TO_W  = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_ev,
  input  logic             b_ev,
  input  logic [TO_W-1:0]  tmo,
  output logic             armed_o,
  output logic             trig_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [TO_W-1:0]  tmr_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  seq_st_t          st_q;
  logic [TO_W-1:0]  tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_WAIT_A;
      tmr_q  <= '0;
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      case (st_q)
        ST_WAIT_A: begin
          if (a_ev) begin
            st_q  <= ST_WAIT_B;
            tmr_q <= TO_W'(1);
          end
        end
        default: begin
          if (b_ev) begin
            trig_q <= 1'b1;
            st_q   <= ST_WAIT_A;
            tmr_q  <= '0;
            if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CNT_W'(1);
          end else if (a_ev) begin
            tmr_q <= TO_W'(1);
          end else if (tmr_q >= tmo) begin
            st_q  <= ST_WAIT_A;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + TO_W'(1);
          end
        end
      endcase
    end
  end

  assign armed_o = (st_q == ST_WAIT_B);
  assign trig_o  = trig_q;
  assign cnt_o   = cnt_q;
  assign tmr_o   = tmr_q;
endmodule

// File: rtl/seq_glitch_trig.sv
module seq_glitch_trig
  import sgt_pkg::*;
#(
  parameter int TO_W  = 24,
  parameter int CNT_W = 16,
  parameter int WID_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [SMP_W-1:0] lo_smp,
  input  logic signed [SMP_W-1:0] hi_smp,
  input  logic signed [SMP_W-1:0] lo_lvl,
  input  logic [HYS_W-1:0]        lo_hyst,
  input  logic signed [SMP_W-1:0] hi_lvl,
  input  logic [HYS_W-1:0]        hi_hyst,
  input  logic                    hi_pol_pos,
  input  logic [WID_W-1:0]        hi_wmax,
  input  logic [TO_W-1:0]         tmo_len,
  output logic                    trig_o,
  output logic                    armed_o,
  output logic [CNT_W-1:0]        trig_cnt_o
);
  // named internal events
  logic            a_ev;
  logic            glitch_w;
  logic [TO_W-1:0] tmr_w;

  sgt_fall_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .smp   (lo_smp),
    .lvl   (lo_lvl),
    .hyst  (lo_hyst),
    .fall_o(a_ev)
  );

  sgt_glitch #(.WID_W(WID_W)) u_glitch (
    .clk     (clk),
    .rst     (rst),
    .smp     (hi_smp),
    .lvl     (hi_lvl),
    .hyst    (hi_hyst),
    .pos     (hi_pol_pos),
    .wmax    (hi_wmax),
    .glitch_o(glitch_w)
  );

  sgt_seq #(.TO_W(TO_W), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .a_ev   (a_ev),
    .b_ev   (glitch_w),
    .tmo    (tmo_len),
    .armed_o(armed_o),
    .trig_o (trig_o),
    .cnt_o  (trig_cnt_o),
    .tmr_o  (tmr_w)
  );
endmodule

// File: rtl/sgt_checker.sv
module sgt_checker #(
  parameter int TO_W  = 24,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_o,
  input logic             armed_o,
  input logic [CNT_W-1:0] cnt,
  input logic [TO_W-1:0]  tmr,
  input logic             a_ev,
  input logic             b_raw,
  input logic [TO_W-1:0]  cfg_tmo
);
  logic [TO_W-1:0] win;
  assign win = (cfg_tmo == '0) ? TO_W'(1) : cfg_tmo;

  assert_arm_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && a_ev) |=> armed_o);

  assert_unarmed_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && b_raw) |=> !trig_o);

  assert_trig_needs_arm_R7: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> $past(armed_o));

  assert_trig_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);

  assert_window_bound_R8: assert property (@(posedge clk) disable iff (rst)
    armed_o |-> (tmr >= TO_W'(1) && tmr <= win));

  assert_b_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (armed_o && a_ev && b_raw) |=> (trig_o && !armed_o));

  assert_cnt_step_R11: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || ((&$past(cnt)) && (cnt == $past(cnt)))));

  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !trig_o |-> $stable(cnt));
endmodule

bind seq_glitch_trig sgt_checker #(.TO_W(TO_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .trig_o (trig_o),
  .armed_o(armed_o),
  .cnt    (trig_cnt_o),
  .tmr    (tmr_w),
  .a_ev   (a_ev),
  .b_raw  (glitch_w),
  .cfg_tmo(tmo_len)
);

// File: tb/seq_glitch_trig_tb.sv
module seq_glitch_trig_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] lo_smp = '0, hi_smp = '0;
  logic signed [11:0] lo_lvl = 12'sd1000, hi_lvl = 12'sd500;
  logic [10:0] lo_hyst = 11'd100, hi_hyst = 11'd50;
  logic hi_pol_pos = 1'b1;
  logic [7:0] hi_wmax = 8'd3;
  logic [23:0] tmo_len = 24'd10;
  logic trig_o, armed_o, trig_s, armed_s;
  logic [15:0] cnt;
  logic [2:0] cnt_s;
  int n_chk = 0, n_bad = 0, exp_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seq_glitch_trig u_dut (
    .clk(clk), .rst(rst), .lo_smp(lo_smp), .hi_smp(hi_smp),
    .lo_lvl(lo_lvl), .lo_hyst(lo_hyst), .hi_lvl(hi_lvl), .hi_hyst(hi_hyst),
    .hi_pol_pos(hi_pol_pos), .hi_wmax(hi_wmax), .tmo_len(tmo_len),
    .trig_o(trig_o), .armed_o(armed_o), .trig_cnt_o(cnt));

  seq_glitch_trig #(.CNT_W(3)) u_sat (
    .clk(clk), .rst(rst), .lo_smp(lo_smp), .hi_smp(hi_smp),
    .lo_lvl(lo_lvl), .lo_hyst(lo_hyst), .hi_lvl(hi_lvl), .hi_hyst(hi_hyst),
    .hi_pol_pos(hi_pol_pos), .hi_wmax(hi_wmax), .tmo_len(tmo_len),
    .trig_o(trig_s), .armed_o(armed_s), .trig_cnt_o(cnt_s));

  typedef struct packed {
    logic signed [11:0] lo;
    logic signed [11:0] hi;
    logic               trig;
    logic               armed;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{12'sd2000, 12'sd0,   1'b0, 1'b0},  // raise low side above band
    '{12'sd900,  12'sd0,   1'b0, 1'b1},  // R2 edge arms
    '{12'sd900,  12'sd600, 1'b0, 1'b1},  // pulse start
    '{12'sd900,  12'sd0,   1'b1, 1'b0},  // R7 width 1 fires
    '{12'sd900,  12'sd0,   1'b0, 1'b0},  // R7 single pulse
    '{12'sd900,  12'sd600, 1'b0, 1'b0},  // R6 unarmed pulse
    '{12'sd900,  12'sd0,   1'b0, 1'b0},  // R6 ignored
    '{12'sd1050, 12'sd0,   1'b0, 1'b0},  // R3 inside band only
    '{12'sd900,  12'sd0,   1'b0, 1'b0},  // R3 no edge
    '{12'sd1100, 12'sd0,   1'b0, 1'b0},  // reaches band
    '{12'sd1050, 12'sd0,   1'b0, 1'b0},
    '{12'sd999,  12'sd0,   1'b0, 1'b1},  // R2 arms
    '{12'sd999,  12'sd600, 1'b0, 1'b1},  // R4 long pulse w1
    '{12'sd999,  12'sd600, 1'b0, 1'b1},
    '{12'sd999,  12'sd600, 1'b0, 1'b1},
    '{12'sd999,  12'sd600, 1'b0, 1'b1},  // w4
    '{12'sd999,  12'sd0,   1'b0, 1'b1},  // R4 too wide
    '{12'sd999,  12'sd600, 1'b0, 1'b1},  // w1
    '{12'sd999,  12'sd600, 1'b0, 1'b1},
    '{12'sd999,  12'sd600, 1'b0, 1'b1},  // w3
    '{12'sd999,  12'sd0,   1'b1, 1'b0}   // R4 width at limit fires
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic signed [11:0] lo, logic signed [11:0] hi);
    @(negedge clk);
    lo_smp = lo;
    hi_smp = hi;
    @(posedge clk);
    #2;
  endtask

  task automatic arm();
    step(12'sd1200, 12'sd0);
    step(12'sd900, 12'sd0);
    chk("R2 arm", armed_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset armed", armed_o, 0);
    chk("R1 reset trig", trig_o, 0);
    chk("R1 reset cnt", cnt, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].lo, VEC[i].hi);
      if (VEC[i].trig) exp_cnt++;
      chk($sformatf("R2 R3 R4 R6 R7 vec %0d trig", i), trig_o, VEC[i].trig);
      chk($sformatf("R2 R3 R4 R6 R7 vec %0d armed", i), armed_o, VEC[i].armed);
    end

    // R8 timeout after sample N
    arm();
    for (int k = 1; k <= 10; k++) begin
      step(12'sd900, 12'sd0);
      chk($sformatf("R8 window k=%0d", k), armed_o, (k < 10) ? 1 : 0);
    end
    step(12'sd900, 12'sd600);
    step(12'sd900, 12'sd0);
    chk("R8 late glitch", trig_o, 0);

    // R8 glitch ending on sample N
    arm();
    for (int k = 1; k <= 8; k++) step(12'sd900, 12'sd0);
    step(12'sd900, 12'sd600);
    step(12'sd900, 12'sd0);
    exp_cnt++;
    chk("R8 last sample trig", trig_o, 1);
    chk("R8 last sample armed", armed_o, 0);

    // R9 reload
    arm();
    for (int k = 1; k <= 7; k++) step(12'sd900, 12'sd0);
    step(12'sd1200, 12'sd0);
    step(12'sd900, 12'sd0);
    for (int k = 1; k <= 9; k++) step(12'sd900, 12'sd0);
    chk("R9 reloaded still armed", armed_o, 1);
    step(12'sd900, 12'sd0);
    chk("R9 reloaded expiry", armed_o, 0);

    // R5 return hysteresis
    arm();
    step(12'sd900, 12'sd600);
    step(12'sd900, 12'sd470);
    chk("R5 inside band no end", trig_o, 0);
    step(12'sd900, 12'sd0);
    exp_cnt++;
    chk("R5 end after band", trig_o, 1);

    // R10 simultaneous edge and glitch end
    arm();
    step(12'sd1200, 12'sd600);
    step(12'sd900, 12'sd0);
    exp_cnt++;
    chk("R10 trig", trig_o, 1);
    chk("R10 armed", armed_o, 0);

    // R4 negative polarity
    hi_pol_pos = 1'b0;
    hi_lvl = -12'sd500;
    arm();
    step(12'sd900, -12'sd600);
    chk("R4 neg start", trig_o, 0);
    step(12'sd900, 12'sd0);
    exp_cnt++;
    chk("R4 neg trig", trig_o, 1);
    step(12'sd900, 12'sd0);
    hi_pol_pos = 1'b1;
    hi_lvl = 12'sd500;

    // R11 burst for counting and saturation
    for (int j = 0; j < 4; j++) begin
      arm();
      step(12'sd900, 12'sd600);
      step(12'sd900, 12'sd0);
      exp_cnt++;
      chk("R7 burst trig", trig_o, 1);
      step(12'sd900, 12'sd0);
      chk("R7 pulse one cycle", trig_o, 0);
    end
    chk("R11 count", cnt, exp_cnt);
    chk("R11 saturated count", cnt_s, (exp_cnt > 7) ? 7 : exp_cnt);

    // R1 reset mid-run
    arm();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 rerst armed", armed_o, 0);
    chk("R1 rerst cnt", cnt, 0);
    chk("R1 rerst trig", trig_o, 0);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule